// File: doc/BRIEF.md
# Microcoded Datapath ALU with Output Shifter

This block is the arithmetic stage of a microprogrammed, stack-oriented datapath. Its left operand is always the value of the dedicated holding register H; its right operand is whatever the shared B bus carries in the current microinstruction. Eight control bits from the microinstruction set its behaviour. Two of them pick a base function. Two gate the operands one by one. One inverts the gated left operand, and one forces a carry into bit 0. The last two steer a shift stage on the result. The shifted value drives the C bus, which is then written into any set of datapath registers.

The six function bits reach the common microoperations without an operation list. Pass-through of B loads H. Increment and decrement use the carry and the inverted left operand. Negation of H uses the same two bits. B minus H is the only subtraction the datapath allows. The negative and zero status of the unshifted result is available at once. A registered copy is held for the microsequencer, which ORs it into the high bit of its next address when the microinstruction asks for a conditional branch.

Top module: `uarch_alu_shift`

## Requirements
- R1: With fn = 2'b00 the unshifted result is the bitwise AND of the prepared left operand and the gated right operand.
- R2: With fn = 2'b01 the unshifted result is the bitwise OR of the prepared left operand and the gated right operand.
- R3: With fn = 2'b10 the unshifted result is the bitwise complement of the gated right operand. The left operand has no effect, and a disabled right input yields all ones.
- R4: With fn = 2'b11 the unshifted result is left + right + carry_in, modulo 2^WIDTH.
- R5: An operand whose enable is low contributes zero. So en_left = 0, en_right = 1 and fn = 2'b11 pass the B bus through unchanged.
- R6: inv_left complements the left operand after its gate. With ADD this yields -H (en_left, inv_left and carry_in), B - 1 (inv_left with en_left low), and B - H (both enables, inv_left and carry_in).
- R7: carry_in changes the result only when fn = 2'b11.
- R8: shl alone shifts the result left by SHL_AMT bits (default 8) and fills with zeros.
- R9: sra alone shifts the result right by SHR_AMT bits (default 1) and copies the sign bit in.
- R10: shl and sra asserted together give no shift.
- R11: neg_now is bit WIDTH-1 of the unshifted result, and zero_now is high exactly when the unshifted result is all zeros. The shifter never affects either.
- R12: neg_q and zero_q take neg_now and zero_now at each rising clock edge and are 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset of the status flip-flops |
| hold_val | input | WIDTH | Value of the holding register H (left operand) |
| bbus_val | input | WIDTH | Value on the B bus (right operand) |
| ctl_fn | input | 2 | Base function: 00 AND, 01 OR, 10 NOT right, 11 ADD |
| ctl_en_left | input | 1 | Gate for the left operand |
| ctl_en_right | input | 1 | Gate for the right operand |
| ctl_inv_left | input | 1 | Complement the gated left operand |
| ctl_carry_in | input | 1 | Carry forced into bit 0 of the adder |
| ctl_shl | input | 1 | Left shift by SHL_AMT with zero fill |
| ctl_sra | input | 1 | Arithmetic right shift by SHR_AMT |
| cbus_out | output | WIDTH | Shifted result driven onto the C bus |
| neg_now | output | 1 | Sign of the unshifted result |
| zero_now | output | 1 | Unshifted result is zero |
| neg_q | output | 1 | Registered negative flag for the sequencer |
| zero_q | output | 1 | Registered zero flag for the sequencer |

## Verification
Every path except the status flip-flops is combinational. A wrong gate, inversion, carry or shift therefore shows on cbus_out, neg_now or zero_now in the same cycle as the control word that exposes it. A fault in the flag registers, such as a missed capture, a wrong reset value, or flags taken after the shifter, shows on neg_q and zero_q one edge after that control word. It would send the sequencer down the wrong branch in the next microinstruction. The stimulus therefore includes control words that differ only in one bit, and words where shifting changes the sign or zero status of the result.

// File: rtl/uas_pkg.sv
`timescale 1ns/1ps
package uas_pkg;
   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_ADD  = 2'b11
   } alu_fn_e;

   // adder construction variants
   localparam int ADDER_INFER  = 0;
   localparam int ADDER_RIPPLE = 1;
endpackage

// File: rtl/uas_operand_gate.sv
`timescale 1ns/1ps
module uas_operand_gate #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] hold_val,
   input  logic [WIDTH-1:0] bbus_val,
   input  logic             en_left,
   input  logic             en_right,
   input  logic             inv_left,
   output logic [WIDTH-1:0] left_op,
   output logic [WIDTH-1:0] right_op
);
   logic [WIDTH-1:0] left_gated;

   always_comb begin
      left_gated = en_left  ? hold_val : '0;
      left_op    = inv_left ? ~left_gated : left_gated;
      right_op   = en_right ? bbus_val : '0;
   end
endmodule

// File: rtl/uas_func_core.sv
`timescale 1ns/1ps
module uas_func_core
   import uas_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = ADDER_INFER
) (
   input  logic [WIDTH-1:0] left_op,
   input  logic [WIDTH-1:0] right_op,
   input  logic [1:0]       fn,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result
);
   logic [WIDTH-1:0] sum;

   generate
      if (ADDER_STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = carry_in;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = left_op[i] ^ right_op[i] ^ carry[i];
            assign carry[i+1] = (left_op[i] & right_op[i]) |
                                (carry[i] & (left_op[i] ^ right_op[i]));
         end
      end else begin : g_infer
         assign sum = left_op + right_op + {{(WIDTH-1){1'b0}}, carry_in};
      end
   endgenerate

   always_comb begin
      unique case (alu_fn_e'(fn))
         FN_AND:  result = left_op & right_op;
         FN_OR:   result = left_op | right_op;
         FN_NOTB: result = ~right_op;
         FN_ADD:  result = sum;
         default: result = sum;
      endcase
   end
endmodule

// File: rtl/uas_shifter.sv
`timescale 1ns/1ps
module uas_shifter #(
   parameter int WIDTH     = 32,
   parameter int SHL_AMT   = 8,
   parameter int SHR_AMT   = 1,
   parameter bit SHR_ARITH = 1'b1
) (
   input  logic [WIDTH-1:0] din,
   input  logic             shl,
   input  logic             sra,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] left_res;
   logic [WIDTH-1:0] right_res;

   assign left_res = din << SHL_AMT;

   generate
      if (SHR_ARITH) begin : g_arith
         assign right_res = WIDTH'($signed(din) >>> SHR_AMT);
      end else begin : g_logic
         assign right_res = din >> SHR_AMT;
      end
   endgenerate

   always_comb begin
      unique case ({shl, sra})
         2'b10:   dout = left_res;
         2'b01:   dout = right_res;
         default: dout = din;   // none, or the illegal pair
      endcase
   end
endmodule

// File: rtl/uas_flag_reg.sv
`timescale 1ns/1ps
module uas_flag_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_res,
   output logic             neg_now,
   output logic             zero_now,
   output logic             neg_q,
   output logic             zero_q
);
   assign neg_now  = raw_res[WIDTH-1];
   assign zero_now = (raw_res == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q  <= 1'b0;
         zero_q <= 1'b0;
      end else begin
         neg_q  <= neg_now;
         zero_q <= zero_now;
      end
   end
endmodule

// File: rtl/uarch_alu_shift.sv
`timescale 1ns/1ps
module uarch_alu_shift
   import uas_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SHL_AMT     = 8,
   parameter int SHR_AMT     = 1,
   parameter bit SHR_ARITH   = 1'b1,
   parameter int ADDER_STYLE = ADDER_INFER
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hold_val,
   input  logic [WIDTH-1:0] bbus_val,
   input  logic [1:0]       ctl_fn,
   input  logic             ctl_en_left,
   input  logic             ctl_en_right,
   input  logic             ctl_inv_left,
   input  logic             ctl_carry_in,
   input  logic             ctl_shl,
   input  logic             ctl_sra,
   output logic [WIDTH-1:0] cbus_out,
   output logic             neg_now,
   output logic             zero_now,
   output logic             neg_q,
   output logic             zero_q
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("uarch_alu_shift: WIDTH must be at least 2");
      end
      if (SHL_AMT < 1 || SHL_AMT >= WIDTH) begin : g_bad_shl
         $error("uarch_alu_shift: SHL_AMT out of range");
      end
      if (SHR_AMT < 1 || SHR_AMT >= WIDTH) begin : g_bad_shr
         $error("uarch_alu_shift: SHR_AMT out of range");
      end
      if (ADDER_STYLE != ADDER_INFER && ADDER_STYLE != ADDER_RIPPLE) begin : g_bad_add
         $error("uarch_alu_shift: unknown ADDER_STYLE");
      end
   endgenerate

   logic [WIDTH-1:0] left_op;
   logic [WIDTH-1:0] right_op;
   logic [WIDTH-1:0] alu_raw;

   uas_operand_gate #(.WIDTH(WIDTH)) u_gate (
      .hold_val (hold_val),
      .bbus_val (bbus_val),
      .en_left  (ctl_en_left),
      .en_right (ctl_en_right),
      .inv_left (ctl_inv_left),
      .left_op  (left_op),
      .right_op (right_op)
   );

   uas_func_core #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_core (
      .left_op  (left_op),
      .right_op (right_op),
      .fn       (ctl_fn),
      .carry_in (ctl_carry_in),
      .result   (alu_raw)
   );

   uas_shifter #(
      .WIDTH(WIDTH), .SHL_AMT(SHL_AMT), .SHR_AMT(SHR_AMT), .SHR_ARITH(SHR_ARITH)
   ) u_shift (
      .din  (alu_raw),
      .shl  (ctl_shl),
      .sra  (ctl_sra),
      .dout (cbus_out)
   );

   uas_flag_reg #(.WIDTH(WIDTH)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_res  (alu_raw),
      .neg_now  (neg_now),
      .zero_now (zero_now),
      .neg_q    (neg_q),
      .zero_q   (zero_q)
   );
endmodule

// File: rtl/uas_chk.sv
`timescale 1ns/1ps
module uas_chk #(
   parameter int WIDTH   = 32,
   parameter int SHL_AMT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       fn,
   input logic             en_right,
   input logic             shl,
   input logic             sra,
   input logic [WIDTH-1:0] alu_raw,
   input logic [WIDTH-1:0] cbus_out,
   input logic             neg_now,
   input logic             zero_now,
   input logic             neg_q,
   input logic             zero_q
);
   // R12
   flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (neg_q == $past(neg_now) && zero_q == $past(zero_now)));

   // R10
   no_double_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shl && sra) |-> (cbus_out == alu_raw));

   // R8
   shl_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shl && !sra) |-> (cbus_out[SHL_AMT-1:0] == '0));

   // R9
   sra_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sra && !shl) |-> (cbus_out[WIDTH-1] == alu_raw[WIDTH-1]));

   // R3
   notb_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fn == 2'b10 && !en_right) |-> (alu_raw == '1));

   // R11
   flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_now |-> !neg_now);
endmodule

bind uarch_alu_shift uas_chk #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fn       (ctl_fn),
   .en_right (ctl_en_right),
   .shl      (ctl_shl),
   .sra      (ctl_sra),
   .alu_raw  (alu_raw),
   .cbus_out (cbus_out),
   .neg_now  (neg_now),
   .zero_now (zero_now),
   .neg_q    (neg_q),
   .zero_q   (zero_q)
);

// File: tb/sim_uarch_alu_shift.sv
`timescale 1ns/1ps
module sim_uarch_alu_shift;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] hold_val = '0, bbus_val = '0;
   logic [1:0]   ctl_fn = 2'b00;
   logic         ctl_en_left = 1'b0, ctl_en_right = 1'b0, ctl_inv_left = 1'b0;
   logic         ctl_carry_in = 1'b0, ctl_shl = 1'b0, ctl_sra = 1'b0;
   logic [W-1:0] cbus_out;
   logic         neg_now, zero_now, neg_q, zero_q;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [W-1:0] cbus;
      logic         neg;
      logic         zero;
      string        tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   uarch_alu_shift u0 (
      .clk(clk), .rst_n(rst_n), .hold_val(hold_val), .bbus_val(bbus_val),
      .ctl_fn(ctl_fn), .ctl_en_left(ctl_en_left), .ctl_en_right(ctl_en_right),
      .ctl_inv_left(ctl_inv_left), .ctl_carry_in(ctl_carry_in),
      .ctl_shl(ctl_shl), .ctl_sra(ctl_sra), .cbus_out(cbus_out),
      .neg_now(neg_now), .zero_now(zero_now), .neg_q(neg_q), .zero_q(zero_q)
   );

   // reference model written from the requirements
   function automatic logic [W-1:0] ref_raw(logic [W-1:0] h, logic [W-1:0] b,
         logic [1:0] fn, logic el, logic er, logic inv, logic cin);
      logic [W-1:0] a, r;
      a = el ? h : '0;
      if (inv) a = ~a;
      r = er ? b : '0;
      case (fn)
         2'b00:   return a & r;
         2'b01:   return a | r;
         2'b10:   return ~r;
         default: return a + r + {31'd0, cin};
      endcase
   endfunction

   task automatic drive(string tag, logic [W-1:0] h, logic [W-1:0] b,
         logic [1:0] fn, logic el, logic er, logic inv, logic cin,
         logic shl, logic sra);
      exp_t e;
      logic [W-1:0] raw;
      @(negedge clk);
      hold_val = h; bbus_val = b; ctl_fn = fn;
      ctl_en_left = el; ctl_en_right = er; ctl_inv_left = inv;
      ctl_carry_in = cin; ctl_shl = shl; ctl_sra = sra;
      raw = ref_raw(h, b, fn, el, er, inv, cin);
      if (shl && !sra)      e.cbus = raw << 8;
      else if (sra && !shl) e.cbus = {raw[W-1], raw[W-1:1]};
      else                  e.cbus = raw;
      e.neg  = raw[W-1];
      e.zero = (raw == '0);
      e.tag  = tag;
      sb.push_back(e);
   endtask

   // monitor: one edge after drive, combinational outputs still hold the
   // driven word and the registered flags have just taken its status
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (cbus_out !== e.cbus || neg_now !== e.neg || zero_now !== e.zero ||
                neg_q !== e.neg || zero_q !== e.zero) begin
               n_bad++;
               $display("FAIL %s: cbus=%h n=%b z=%b nq=%b zq=%b expected cbus=%h n=%b z=%b",
                        e.tag, cbus_out, neg_now, zero_now, neg_q, zero_q,
                        e.cbus, e.neg, e.zero);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R12: reset holds the flags at 0 while the input word is negative
      hold_val = 32'h8000_0000; ctl_fn = 2'b11; ctl_en_left = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if (neg_q !== 1'b0 || zero_q !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 reset: nq=%b zq=%b expected nq=0 zq=0", neg_q, zero_q);
      end
      @(negedge clk);
      rst_n = 1'b1;

      drive("R1 and",        32'hF0F0_1234, 32'h0FF0_FFFF, 2'b00, 1,1,0,0, 0,0);
      drive("R1 and inv",    32'h0000_FFFF, 32'h1234_5678, 2'b00, 1,1,1,0, 0,0);
      drive("R2 or",         32'h8000_0001, 32'h0000_0F00, 2'b01, 1,1,0,0, 0,0);
      drive("R3 notb",       32'h5555_5555, 32'h0000_00FF, 2'b10, 1,1,0,0, 0,0);
      drive("R3 notb off",   32'h1234_5678, 32'hDEAD_BEEF, 2'b10, 1,0,0,0, 0,0);
      drive("R3 notb zero",  32'h0000_0001, 32'hFFFF_FFFF, 2'b10, 1,1,0,1, 0,0);
      drive("R4 add ovf",    32'h7FFF_FFFF, 32'h0000_0001, 2'b11, 1,1,0,0, 0,0);
      drive("R4 add wrap",   32'hFFFF_FFFF, 32'h0000_0000, 2'b11, 1,1,0,1, 0,0);
      drive("R5 pass b",     32'hAAAA_AAAA, 32'h0000_1234, 2'b11, 0,1,0,0, 0,0);
      drive("R5 both off",   32'hAAAA_AAAA, 32'h5555_5555, 2'b01, 0,0,0,0, 0,0);
      drive("R6 negate",     32'h0000_0005, 32'h0000_0009, 2'b11, 1,0,1,1, 0,0);
      drive("R6 decrement",  32'h0000_0077, 32'h0000_000A, 2'b11, 0,1,1,0, 0,0);
      drive("R6 sub neg",    32'h0000_0007, 32'h0000_0003, 2'b11, 1,1,1,1, 0,0);
      drive("R6 sub eq",     32'h0000_0003, 32'h0000_0003, 2'b11, 1,1,1,1, 0,0);
      drive("R7 or cin",     32'h0000_00F0, 32'h0000_000F, 2'b01, 1,1,0,1, 0,0);
      drive("R7 and cin",    32'h0000_00F0, 32'h0000_00FF, 2'b00, 1,1,0,1, 0,0);
      drive("R8 shl",        32'h0000_0000, 32'h1234_5678, 2'b11, 0,1,0,0, 1,0);
      drive("R8 shl to zero",32'h0000_0000, 32'h8000_0000, 2'b11, 0,1,0,0, 1,0);
      drive("R9 sra neg",    32'h0000_0000, 32'h8000_0010, 2'b11, 0,1,0,0, 0,1);
      drive("R9 sra one",    32'h0000_0000, 32'h0000_0001, 2'b11, 0,1,0,0, 0,1);
      drive("R10 both",      32'h0000_0000, 32'h8123_4567, 2'b11, 0,1,0,0, 1,1);
      drive("R11 flags neg", 32'h8000_0000, 32'h0000_0000, 2'b11, 1,1,0,0, 0,0);
      drive("R11 flags zero",32'h0000_0000, 32'h0000_0000, 2'b01, 1,1,0,0, 0,0);

      while (sb.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule